// File: doc/BRIEF.md
# Time Base Interrupt Timer

The block produces a periodic interrupt request from a free-running binary divider of the main clock. A 24-bit counter advances on every clock cycle and is cleared only by the system reset. One of eight counter taps is picked by a 3-bit select code. The request fires on each falling edge of that tap while the timer is enabled.

Software programs the block through one byte-wide control register. Bits 2:0 hold the select code and bit 3 holds the enable. A static mode input chooses between two tap tables: the alternate table halves every rate of the default one.

A two-state machine tracks the enable. The states are `ST_OFF` and `ST_RUN`, and they have four transitions:
- `HOLD_OFF`: a write with bit 3 clear while off.
- `START`: a write with bit 3 set while off. This transition also loads the select code.
- `KEEP`: a write with bit 3 set while running.
- `STOP`: a write with bit 3 clear while running.

The select code is frozen whenever the machine is in `ST_RUN`. The divider is never restarted, so the first period after enabling may be shorter than a full period.

Top module: `tbase_irq_timer`

## Requirements
- R1: After reset, `rd_data` reads 0x00 and `irq` is low.
- R2: `rd_data` returns {4'b0000, enable, select[2:0]}. The enable is in bit 3 and the select is in bits 2:0. Bits 7:4 always read 0, whatever was written to them.
- R3: With `alt_map`=0, the codes 000 to 111 give a request period of 2^23, 2^21, 2^16, 2^14, 2^13, 2^12, 2^11 and 2^9 clock cycles.
- R4: With `alt_map`=1, the same codes give a period of 2^24, 2^22, 2^17, 2^15, 2^14, 2^13, 2^12 and 2^10 cycles.
- R5: Each request is a pulse exactly one clock cycle wide.
- R6: While the enable bit reads 0, `irq` stays low.
- R7: For a period P, a pulse is visible in the cycle P*m+1 after reset, for each m ≥ 1, provided the timer was enabled at least one cycle before. A later enable does not restart this phase, so the first pulse after enabling comes within P+1 cycles.
- R8: A write made while the enable reads 1 leaves the select unchanged. The enable bit of that write is still applied.
- R9: A write made while the enable reads 0 loads both the select and the enable in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alt_map | input | 1 | 0 selects the default tap table, 1 selects the alternate table; change only while disabled |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| rd_data | output | 8 | Control register read-back |
| irq | output | 1 | Interrupt request pulse |

## Verification
A wrong select state shows up at `rd_data` on the clock after the write. It also shifts the pulse spacing, which is visible no later than the second pulse. A divider that is wrongly restarted, or a stale stored tap value, moves the pulse off the P*m+1 grid counted from reset, so the exact cycle of each first pulse is checked. A wrong enable state shows up either as a pulse during a quiet window or as a missing pulse within one period.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
    localparam int SEL_W     = 3;
    localparam int NUM_CODES = 1 << SEL_W;
    localparam int CTRL_W    = 8;
    localparam int EN_BIT    = 3;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } run_state_e;

    // Counter bit whose falling edge marks one period of fc / 2^exponent.
    function automatic int tap_bit(input int code, input bit alt);
        int e;
        unique case (code)
            0:       e = 23;
            1:       e = 21;
            2:       e = 16;
            3:       e = 14;
            4:       e = 13;
            5:       e = 12;
            6:       e = 11;
            default: e = 9;
        endcase
        return e - 1 + (alt ? 1 : 0);
    endfunction
endpackage

// File: rtl/tbase_divider.sv
module tbase_divider #(
    parameter int DIV_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [DIV_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count <= '0;
        else        count <= count + 1'b1;
    end
endmodule

// File: rtl/tbase_edge_sel.sv
module tbase_edge_sel #(
    parameter int DIV_W = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [DIV_W-1:0]           count,
    input  logic                       alt_map,
    input  logic [tbase_pkg::SEL_W-1:0] sel,
    output logic                       fall
);
    import tbase_pkg::*;

    logic [NUM_CODES-1:0] taps;
    logic [NUM_CODES-1:0] taps_q;
    logic                 unused_count;

    assign unused_count = ^count;

    for (genvar i = 0; i < NUM_CODES; i++) begin : g_tap
        localparam int DEF_B = tap_bit(i, 1'b0);
        localparam int ALT_B = tap_bit(i, 1'b1);
        assign taps[i] = alt_map ? count[ALT_B] : count[DEF_B];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) taps_q <= '0;
        else        taps_q <= taps;
    end

    assign fall = taps_q[sel] & ~taps[sel];
endmodule

// File: rtl/tbase_ctrl.sv
module tbase_ctrl (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [tbase_pkg::EN_BIT:0]  wr_low,
    output logic                        run,
    output logic [tbase_pkg::SEL_W-1:0] sel
);
    import tbase_pkg::*;

    run_state_e state_q, state_d;
    logic [SEL_W-1:0] sel_q;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            unique case (state_q)
                ST_OFF: state_d = wr_low[EN_BIT] ? ST_RUN : ST_OFF;  // START / HOLD_OFF
                ST_RUN: state_d = wr_low[EN_BIT] ? ST_RUN : ST_OFF;  // KEEP / STOP
                default: state_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (wr_en) begin
            unique case (state_q)
                ST_OFF:  sel_q <= wr_low[SEL_W-1:0];
                ST_RUN:  sel_q <= sel_q;
                default: sel_q <= '0;
            endcase
        end
    end

    assign run = (state_q == ST_RUN);
    assign sel = sel_q;
endmodule

// File: rtl/tbase_irq_timer.sv
module tbase_irq_timer #(
    parameter int DIV_W = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       alt_map,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       irq
);
    import tbase_pkg::*;

    logic [DIV_W-1:0] count;
    logic [SEL_W-1:0] sel;
    logic             run;
    logic             fall;
    logic             irq_q;
    logic             unused_wr_hi;

    assign unused_wr_hi = ^wr_data[CTRL_W-1:EN_BIT+1];

    tbase_divider #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .count (count)
    );

    tbase_edge_sel #(.DIV_W(DIV_W)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .count   (count),
        .alt_map (alt_map),
        .sel     (sel),
        .fall    (fall)
    );

    tbase_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_low (wr_data[EN_BIT:0]),
        .run    (run),
        .sel    (sel)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= run & fall;
    end

    assign irq     = irq_q;
    assign rd_data = {{(CTRL_W-EN_BIT-1){1'b0}}, run, sel};
endmodule

// File: rtl/tbase_irq_timer_chk.sv
module tbase_irq_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       irq
);
    a_r5_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[3] |=> !irq);

    a_r8_select_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[3] && wr_en) |=> (rd_data[2:0] == $past(rd_data[2:0])));

    a_r9_joint_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[3] && wr_en) |=> (rd_data[3:0] == $past(wr_data[3:0])));

    a_r2_enable_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[3] == $past(wr_data[3])));
endmodule

bind tbase_irq_timer tbase_irq_timer_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .irq     (irq)
);

// File: tb/test_tbase_irq_timer.sv
module test_tbase_irq_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alt_map = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    tbase_irq_timer i_tbase_irq_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .alt_map (alt_map),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq     (irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = 8'h00;
    endtask

    // Waits at negedges for a pulse; returns the cycle seen, or -1.
    task automatic wait_pulse(input int limit, output int at);
        at = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (irq) begin
                at = cyc;
                break;
            end
        end
    endtask

    task automatic t_reset_state();
        chk(rd_data == 8'h00, "R1 reset rd_data", rd_data, 0);
        chk(irq == 1'b0, "R1 reset irq", irq, 0);
    endtask

    task automatic t_first_phase();
        int at;
        // enable code 111 on the first edge after reset release
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = 8'h0F;
        rst_n = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk(rd_data == 8'h0F, "R9 joint load", rd_data, 8'h0F);
        wait_pulse(600, at);
        chk(at == 513, "R7 first pulse phase", at, 513);
        @(negedge clk);
        chk(irq == 1'b0, "R5 pulse width", irq, 0);
    endtask

    task automatic t_spacing(input string req, input int period);
        int a;
        int b;
        wait_pulse(period + 4, a);
        chk(a > 0 && ((a - 1) % period) == 0, {req, " pulse on grid"}, a, 1);
        @(negedge clk);
        chk(irq == 1'b0, "R5 pulse width", irq, 0);
        for (int k = 0; k < 2; k++) begin
            wait_pulse(period + 4, b);
            chk(b - a == period, {req, " spacing"}, b - a, period);
            a = b;
        end
    endtask

    task automatic t_locked_select();
        // running with code 111: attempt to switch to 110
        wr(8'h0E);
        chk(rd_data == 8'h0F, "R8 select kept while running", rd_data, 8'h0F);
        t_spacing("R8 old period kept", 512);
        // stop and try to change the code in the same write
        wr(8'h06);
        chk(rd_data == 8'h07, "R8 stop keeps select", rd_data, 8'h07);
    endtask

    task automatic t_quiet_off();
        int n = 0;
        @(negedge clk);
        for (int i = 0; i < 1500; i++) begin
            @(negedge clk);
            if (irq) n++;
        end
        chk(n == 0, "R6 no pulse when disabled", n, 0);
    endtask

    task automatic t_upper_bits();
        wr(8'hF5);
        chk(rd_data == 8'h05, "R2 upper bits read 0", rd_data, 8'h05);
        wr(8'hF9);
        chk(rd_data == 8'h09, "R2 readback with enable", rd_data, 8'h09);
        wr(8'h01);
        chk(rd_data == 8'h01, "R2 readback after stop", rd_data, 8'h01);
    endtask

    task automatic t_late_enable();
        int start;
        int at;
        repeat (300) @(negedge clk);
        wr(8'h0F);
        start = cyc;
        wait_pulse(520, at);
        chk(at > 0 && ((at - 1) % 512) == 0, "R7 late enable keeps phase", at, 1);
        chk(at - start <= 513, "R7 first interval within period", at - start, 513);
        wr(8'h07);
    endtask

    task automatic t_code_110();
        wr(8'h0E);
        chk(rd_data == 8'h0E, "R9 joint load 110", rd_data, 8'h0E);
        t_spacing("R3 code 110", 2048);
        wr(8'h06);
    endtask

    task automatic t_alt_map();
        alt_map = 1'b1;
        repeat (3) @(negedge clk);
        wr(8'h0F);
        t_spacing("R4 alt code 111", 1024);
        wr(8'h07);
        repeat (3) @(negedge clk);
        alt_map = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        t_first_phase();
        t_spacing("R3 code 111", 512);
        t_locked_select();
        t_quiet_off();
        t_upper_bits();
        t_late_enable();
        t_code_110();
        t_alt_map();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule